// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block takes a vector of level-sensitive device interrupt lines and routes them to up to four processors. A registered raw request vector holds the current line levels, with one extra legacy bridge input merged into a fixed bit. Each processor has its own 64-bit enable mask. A processor's pending set is its mask ANDed with the raw vector, and its interrupt output is high while that set is not empty.

Each processor also has an interval counter that thins out a periodic timer tick. On every rising tick, each present processor's counter decrements. Once the counter wraps below zero, a sticky overflow flag is set, and every later tick produces a one-cycle event pulse for that processor. Software reloads the counter to skip a chosen number of ticks, and the reload clears the flag. The event pulse is meant to set a timer flag in a separate control register.

Software reaches the masks, pending sets, raw vector and counters through a simple CSR port. The port accepts a request on every cycle and never applies back-pressure. A read returns one cycle after it is accepted.

Top module: `irq_cpu_router`

## Requirements
- R1: Raw bit n is the level of `dev_irq_i[n]`, registered once. `legacy_irq_i` is ORed into raw bit 55 (parameter `LEGACY_BIT`). The raw vector reads at offset 0x300.
- R2: For CPU i, the pending value is mask_i AND raw. `cpu_irq_o[i]` is the OR of all its bits. The pending values read at offsets 0x280, 0x2C0, 0x680 and 0x6C0 for CPU 0 to CPU 3.
- R3: The masks live at offsets 0x200, 0x240, 0x600 and 0x640 for CPU 0 to CPU 3. A write stores all 64 bits. The new mask drives `cpu_irq_o` from the cycle after the write.
- R4: Writes to the pending offsets or the raw offset change nothing and raise no error.
- R5: The counters live at offsets 0x380, 0x3C0, 0x700 and 0x740 for CPU 0 to CPU 3. A write stores `wdata[23:0]` and clears bit 24, the overflow flag. A read returns bits [24:0] zero-extended.
- R6: On a tick cycle (`tick_i` high after being low), each present CPU's counter bits [24:0] decrement modulo 2^25, and bit 24 stays set once it is set. Holding `tick_i` high, or its falling edge, causes no further decrement. If a counter write and a tick fall in the same cycle, the write wins.
- R7: If bit 24 is set after a tick's decrement, `cpu_tick_o[i]` is high for exactly the one cycle after the tick cycle.
- R8: An access to any other offset raises `csr_err_o` for one cycle, in the cycle after the access. A read of such an offset returns all ones together with the error.
- R9: Every request is accepted. A read gives exactly one `csr_rvalid_o` cycle, one cycle after the request, and a write gives none.
- R10: CPUs whose bit in `CPU_PRESENT` is clear (default 4'b1011, so CPU 2 is absent) hold `cpu_irq_o` and `cpu_tick_o` at zero, and their counters do not decrement. Their registers stay accessible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq_i | input | 64 | Device interrupt levels |
| legacy_irq_i | input | 1 | Legacy bridge interrupt level, merged into raw bit 55 |
| tick_i | input | 1 | Periodic timer tick level |
| csr_req_i | input | 1 | CSR access request, always accepted |
| csr_we_i | input | 1 | 1 = write, 0 = read |
| csr_addr_i | input | 12 | CSR byte offset |
| csr_wdata_i | input | 64 | Write data |
| csr_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| csr_rdata_o | output | 64 | Read data |
| csr_err_o | output | 1 | One-cycle strobe for an unmapped access |
| cpu_irq_o | output | 4 | Device interrupt level per CPU |
| cpu_tick_o | output | 4 | Timer event pulse per CPU |

## Verification
The bench steps one counter down through zero. A design that did not wrap modulo 2^25, or that did not keep the overflow flag sticky, would miss the pulse at the wrap or on the ticks after it. The tick is held high for several cycles, which exposes a design that decrements on the level instead of the edge. A counter write in the same cycle as a tick exposes a design that lets the tick win. The bench also checks that an absent CPU's counter stays frozen and its outputs stay zero, and that the legacy input only affects raw bit 55. Writes to read-only offsets and accesses to unmapped offsets must leave the state unchanged and give exactly one error strobe, with all-ones data on a read.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int CSR_AW  = 12;
  localparam int DATA_W  = 64;
  localparam int MAX_CPU = 4;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_MASK,
    REG_PEND,
    REG_RAW,
    REG_CNT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [1:0]  cpu;
  } reg_sel_t;

  function automatic reg_sel_t decode_off(input logic [CSR_AW-1:0] off);
    reg_sel_t s;
    s.kind = REG_NONE;
    s.cpu  = 2'd0;
    case (off)
      12'h200: begin s.kind = REG_MASK; s.cpu = 2'd0; end
      12'h240: begin s.kind = REG_MASK; s.cpu = 2'd1; end
      12'h600: begin s.kind = REG_MASK; s.cpu = 2'd2; end
      12'h640: begin s.kind = REG_MASK; s.cpu = 2'd3; end
      12'h280: begin s.kind = REG_PEND; s.cpu = 2'd0; end
      12'h2C0: begin s.kind = REG_PEND; s.cpu = 2'd1; end
      12'h680: begin s.kind = REG_PEND; s.cpu = 2'd2; end
      12'h6C0: begin s.kind = REG_PEND; s.cpu = 2'd3; end
      12'h380: begin s.kind = REG_CNT;  s.cpu = 2'd0; end
      12'h3C0: begin s.kind = REG_CNT;  s.cpu = 2'd1; end
      12'h700: begin s.kind = REG_CNT;  s.cpu = 2'd2; end
      12'h740: begin s.kind = REG_CNT;  s.cpu = 2'd3; end
      12'h300: begin s.kind = REG_RAW;  s.cpu = 2'd0; end
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/irq_router_csrdec.sv
module irq_router_csrdec
  import irq_router_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [CSR_AW-1:0] addr_i,
  output reg_sel_t          sel_o,
  output logic              unmapped_o,
  output logic [MAX_CPU-1:0] mask_we_o,
  output logic [MAX_CPU-1:0] cnt_we_o
);
  reg_sel_t sel;

  always_comb sel = decode_off(addr_i);

  assign sel_o      = sel;
  assign unmapped_o = (sel.kind == REG_NONE);

  for (genvar c = 0; c < MAX_CPU; c++) begin : g_we
    assign mask_we_o[c] = req_i && we_i && (sel.kind == REG_MASK) && (sel.cpu == 2'(c));
    assign cnt_we_o[c]  = req_i && we_i && (sel.kind == REG_CNT)  && (sel.cpu == 2'(c));
  end
endmodule

// File: rtl/irq_router_lane.sv
module irq_router_lane #(
  parameter int   LINES   = 64,
  parameter int   CNT_W   = 24,
  parameter logic PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  input  logic             mask_we_i,
  input  logic [LINES-1:0] mask_wdata_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             tick_rise_i,
  output logic [LINES-1:0] mask_o,
  output logic [LINES-1:0] pend_o,
  output logic [CNT_W:0]   cnt_o,
  output logic             irq_o,
  output logic             tick_pulse_o
);
  logic [LINES-1:0] mask_q;
  logic [CNT_W:0]   cnt_q;
  logic [CNT_W:0]   dec;
  logic [CNT_W:0]   cnt_next;
  logic             pulse_q;

  assign dec      = cnt_q - 1'b1;
  assign cnt_next = {dec[CNT_W] | cnt_q[CNT_W], dec[CNT_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (cnt_we_i)
        cnt_q <= {1'b0, cnt_wdata_i};
      else if (tick_rise_i && PRESENT)
        cnt_q <= cnt_next;
      pulse_q <= !cnt_we_i && tick_rise_i && PRESENT && cnt_next[CNT_W];
    end
  end

  assign mask_o       = mask_q;
  assign pend_o       = mask_q & raw_i;
  assign cnt_o        = cnt_q;
  assign irq_o        = PRESENT && (|pend_o);
  assign tick_pulse_o = pulse_q;

  // R3
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> mask_q == $past(mask_wdata_i));

  // R5
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> cnt_q == {1'b0, $past(cnt_wdata_i)});

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[CNT_W] && !cnt_we_i) |=> cnt_q[CNT_W]);

  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse_o |-> (cnt_q[CNT_W] && $past(tick_rise_i)));

  // R10
  absent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!PRESENT && !cnt_we_i) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/irq_cpu_router.sv
module irq_cpu_router
  import irq_router_pkg::*;
#(
  parameter int               LINES       = 64,
  parameter int               LEGACY_BIT  = 55,
  parameter int               CNT_W       = 24,
  parameter logic [MAX_CPU-1:0] CPU_PRESENT = 4'b1011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   dev_irq_i,
  input  logic               legacy_irq_i,
  input  logic               tick_i,
  input  logic               csr_req_i,
  input  logic               csr_we_i,
  input  logic [CSR_AW-1:0]  csr_addr_i,
  input  logic [DATA_W-1:0]  csr_wdata_i,
  output logic               csr_rvalid_o,
  output logic [DATA_W-1:0]  csr_rdata_o,
  output logic               csr_err_o,
  output logic [MAX_CPU-1:0] cpu_irq_o,
  output logic [MAX_CPU-1:0] cpu_tick_o
);
  localparam logic [LINES-1:0] LEGACY_MASK = LINES'(1) << LEGACY_BIT;

  logic [LINES-1:0]   raw_q;
  logic               tick_q;
  logic               tick_rise;
  reg_sel_t           sel;
  logic               unmapped;
  logic [MAX_CPU-1:0] mask_we;
  logic [MAX_CPU-1:0] cnt_we;
  logic [LINES-1:0]   mask_a [MAX_CPU];
  logic [LINES-1:0]   pend_a [MAX_CPU];
  logic [CNT_W:0]     cnt_a  [MAX_CPU];
  logic [DATA_W-1:0]  rd_mux;
  logic               rvalid_q;
  logic               err_q;
  logic [DATA_W-1:0]  rdata_q;

  assign tick_rise = tick_i && !tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      raw_q  <= dev_irq_i | (legacy_irq_i ? LEGACY_MASK : '0);
      tick_q <= tick_i;
    end
  end

  irq_router_csrdec u_dec (
    .req_i      (csr_req_i),
    .we_i       (csr_we_i),
    .addr_i     (csr_addr_i),
    .sel_o      (sel),
    .unmapped_o (unmapped),
    .mask_we_o  (mask_we),
    .cnt_we_o   (cnt_we)
  );

  for (genvar c = 0; c < MAX_CPU; c++) begin : g_lane
    irq_router_lane #(
      .LINES   (LINES),
      .CNT_W   (CNT_W),
      .PRESENT (CPU_PRESENT[c])
    ) u_lane (
      .clk          (clk),
      .rst_n        (rst_n),
      .raw_i        (raw_q),
      .mask_we_i    (mask_we[c]),
      .mask_wdata_i (csr_wdata_i[LINES-1:0]),
      .cnt_we_i     (cnt_we[c]),
      .cnt_wdata_i  (csr_wdata_i[CNT_W-1:0]),
      .tick_rise_i  (tick_rise),
      .mask_o       (mask_a[c]),
      .pend_o       (pend_a[c]),
      .cnt_o        (cnt_a[c]),
      .irq_o        (cpu_irq_o[c]),
      .tick_pulse_o (cpu_tick_o[c])
    );

    // R2
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_o[c] |-> (|raw_q));
  end

  always_comb begin
    case (sel.kind)
      REG_MASK: rd_mux = DATA_W'(mask_a[sel.cpu]);
      REG_PEND: rd_mux = DATA_W'(pend_a[sel.cpu]);
      REG_RAW:  rd_mux = DATA_W'(raw_q);
      REG_CNT:  rd_mux = DATA_W'(cnt_a[sel.cpu]);
      default:  rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= csr_req_i && !csr_we_i;
      err_q    <= csr_req_i && unmapped;
      if (csr_req_i && !csr_we_i) rdata_q <= rd_mux;
    end
  end

  assign csr_rvalid_o = rvalid_q;
  assign csr_err_o    = err_q;
  assign csr_rdata_o  = rdata_q;

  // R9
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rvalid_o |-> $past(csr_req_i && !csr_we_i));

  // R8
  unmapped_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_err_o && csr_rvalid_o) |-> (csr_rdata_o == '1));
endmodule

// File: tb/irq_cpu_router_tb.sv
`timescale 1ns/1ps
module irq_cpu_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] dev_irq_i = '0;
  logic        legacy_irq_i = 1'b0;
  logic        tick_i = 1'b0;
  logic        csr_req_i = 1'b0;
  logic        csr_we_i = 1'b0;
  logic [11:0] csr_addr_i = '0;
  logic [63:0] csr_wdata_i = '0;
  logic        csr_rvalid_o;
  logic [63:0] csr_rdata_o;
  logic        csr_err_o;
  logic [3:0]  cpu_irq_o;
  logic [3:0]  cpu_tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] exp_d[$];
  logic        exp_e[$];
  string       exp_tag[$];

  always #10 clk = ~clk;

  irq_cpu_router u_dut (
    .clk(clk), .rst_n(rst_n), .dev_irq_i(dev_irq_i), .legacy_irq_i(legacy_irq_i),
    .tick_i(tick_i), .csr_req_i(csr_req_i), .csr_we_i(csr_we_i),
    .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i),
    .csr_rvalid_o(csr_rvalid_o), .csr_rdata_o(csr_rdata_o), .csr_err_o(csr_err_o),
    .cpu_irq_o(cpu_irq_o), .cpu_tick_o(cpu_tick_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && csr_rvalid_o) begin
      if (exp_d.size() == 0) begin
        check("R9 unexpected read response", 64'd1, 64'd0);
      end else begin
        automatic logic [63:0] d = exp_d.pop_front();
        automatic logic        e = exp_e.pop_front();
        automatic string       t = exp_tag.pop_front();
        check(t, csr_rdata_o, d);
        check({t, " err"}, {63'd0, csr_err_o}, {63'd0, e});
      end
    end
  end

  task automatic csr_read(input logic [11:0] a, input logic [63:0] d, input logic e, input string t);
    exp_d.push_back(d); exp_e.push_back(e); exp_tag.push_back(t);
    csr_req_i = 1'b1; csr_we_i = 1'b0; csr_addr_i = a;
    @(negedge clk);
    csr_req_i = 1'b0;
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
    csr_req_i = 1'b1; csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
    @(negedge clk);
    csr_req_i = 1'b0; csr_we_i = 1'b0;
  endtask

  task automatic tick_once(input logic [3:0] exp, input string t);
    tick_i = 1'b1;
    @(negedge clk);
    check(t, {60'd0, cpu_tick_o}, {60'd0, exp});
    tick_i = 1'b0;
    @(negedge clk);
    check({t, " pulse width"}, {60'd0, cpu_tick_o}, 64'd0);
  endtask

  task automatic finish_run();
    if (exp_d.size() != 0) check("R9 missing read responses", 64'(exp_d.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check("watchdog expired", 64'd1, 64'd0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset irq", {60'd0, cpu_irq_o}, 64'd0);
    check("reset tick", {60'd0, cpu_tick_o}, 64'd0);
    check("reset err/rvalid", {62'd0, csr_err_o, csr_rvalid_o}, 64'd0);
    csr_read(12'h300, 64'd0, 1'b0, "R1 raw after reset");

    // R1: raw vector with legacy input folded into bit 55
    dev_irq_i = (64'd1 << 3) | (64'd1 << 40);
    legacy_irq_i = 1'b1;
    @(negedge clk);
    csr_read(12'h300, 64'h0080_0100_0000_0008, 1'b0, "R1 raw with legacy");

    // R3: mask write takes effect the next cycle
    check("R3 irq0 before mask", {63'd0, cpu_irq_o[0]}, 64'd0);
    csr_write(12'h200, 64'd1 << 3);
    check("R3 irq0 after mask", {63'd0, cpu_irq_o[0]}, 64'd1);
    check("R2 irq1 unmasked", {63'd0, cpu_irq_o[1]}, 64'd0);
    csr_read(12'h280, 64'h8, 1'b0, "R2 pending0");
    csr_read(12'h200, 64'h8, 1'b0, "R3 mask0 readback");

    // R1/R2: legacy-driven interrupt on CPU1
    csr_write(12'h240, 64'd1 << 55);
    check("R2 irq1 via legacy", {63'd0, cpu_irq_o[1]}, 64'd1);
    legacy_irq_i = 1'b0;
    @(negedge clk);
    check("R1 irq1 legacy dropped", {63'd0, cpu_irq_o[1]}, 64'd0);
    dev_irq_i[55] = 1'b1;
    @(negedge clk);
    check("R1 irq1 via line 55", {63'd0, cpu_irq_o[1]}, 64'd1);

    // R10: absent CPU2 stays quiet but its registers work
    csr_write(12'h600, '1);
    check("R10 irq2 absent", {63'd0, cpu_irq_o[2]}, 64'd0);
    csr_read(12'h680, 64'h0080_0100_0000_0008, 1'b0, "R10 pending2 readable");
    csr_write(12'h640, 64'd1 << 40);
    check("R2 irq3", {63'd0, cpu_irq_o[3]}, 64'd1);
    csr_read(12'h6C0, 64'd1 << 40, 1'b0, "R2 pending3");

    // R4: writes to read-only offsets are ignored
    csr_write(12'h280, 64'd0);
    check("R4 no err on pending write", {63'd0, csr_err_o}, 64'd0);
    csr_write(12'h300, 64'd0);
    check("R4 no err on raw write", {63'd0, csr_err_o}, 64'd0);
    check("R4 irq0 kept", {63'd0, cpu_irq_o[0]}, 64'd1);
    csr_read(12'h300, 64'h0080_0100_0000_0008, 1'b0, "R4 raw unchanged");
    csr_read(12'h200, 64'h8, 1'b0, "R4 mask0 unchanged");

    // R5: counter write keeps 24 bits and clears overflow
    csr_write(12'h380, 64'h1AB_CDEF);
    csr_read(12'h380, 64'h0AB_CDEF, 1'b0, "R5 count truncation");

    // R6/R7/R10: tick sequence
    csr_write(12'h380, 64'd2);
    csr_write(12'h3C0, 64'h10);
    csr_write(12'h700, 64'd1);
    csr_write(12'h740, 64'd0);
    tick_once(4'b1000, "R7 tick1");
    tick_once(4'b1000, "R7 tick2 sticky");
    tick_once(4'b1001, "R7 tick3 wrap");
    csr_read(12'h380, 64'h1FF_FFFF, 1'b0, "R6 count0 wrapped");
    csr_read(12'h3C0, 64'h0D, 1'b0, "R6 count1");
    csr_read(12'h700, 64'h1, 1'b0, "R10 count2 frozen");
    csr_read(12'h740, 64'h1FF_FFFD, 1'b0, "R6 count3 sticky");

    // R6: held-high tick decrements once
    tick_i = 1'b1;
    @(negedge clk);
    check("R6 held tick first", {60'd0, cpu_tick_o}, 64'h9);
    @(negedge clk);
    check("R6 held tick second", {60'd0, cpu_tick_o}, 64'd0);
    @(negedge clk);
    check("R6 held tick third", {60'd0, cpu_tick_o}, 64'd0);
    tick_i = 1'b0;
    @(negedge clk);
    check("R6 falling edge", {60'd0, cpu_tick_o}, 64'd0);
    csr_read(12'h3C0, 64'h0C, 1'b0, "R6 count1 single decrement");
    csr_read(12'h380, 64'h1FF_FFFE, 1'b0, "R6 count0");

    // R5: write clears overflow
    csr_write(12'h380, 64'd5);
    csr_read(12'h380, 64'd5, 1'b0, "R5 overflow cleared");

    // R6: write beats a tick in the same cycle
    tick_i = 1'b1;
    csr_req_i = 1'b1; csr_we_i = 1'b1; csr_addr_i = 12'h3C0; csr_wdata_i = 64'd7;
    @(negedge clk);
    csr_req_i = 1'b0; csr_we_i = 1'b0; tick_i = 1'b0;
    check("R6 write vs tick pulses", {60'd0, cpu_tick_o}, 64'h8);
    @(negedge clk);
    csr_read(12'h3C0, 64'd7, 1'b0, "R6 write wins");
    csr_read(12'h380, 64'd4, 1'b0, "R6 count0 ticked");

    // R8: unmapped accesses
    csr_read(12'h208, '1, 1'b1, "R8 unmapped read");
    csr_write(12'h000, 64'h1234);
    check("R8 unmapped write err", {62'd0, csr_err_o, csr_rvalid_o}, 64'h2);
    @(negedge clk);
    check("R8 err one cycle", {63'd0, csr_err_o}, 64'd0);
    csr_read(12'h200, 64'h8, 1'b0, "R8 state kept");

    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule